// File: doc/BRIEF.md
# Serial Sync Word Detector

This block watches a one-bit serial stream for a 16-bit synchronisation word. It takes one bit on every rising clock edge. The word is four back-to-back 4-bit groups. The first, second and fourth groups must each carry the bits 1, 1, 0, 1 in that order of arrival. The third group must carry anything else. When a full word has arrived, the block raises a single-cycle detect pulse that a downstream framer can use as its alignment marker.

A build-time parameter picks one of two search behaviours.

- **Free-running search** examines the most recent 16 bits at every edge, so a word is found at any bit offset.
- **Locked hunt** behaves differently. It commits to the bit alignment of the first matching group it sees. It then judges the later groups only on 4-bit boundaries from that point, and ignores every other alignment while committed. Any group that breaks the rule ends the commitment.

Locked hunt is cheaper in comparisons, but it can miss a word that overlaps a false start.

Top module: `sync_word_finder`

## Requirements
- R1: The serial bit is sampled on each rising clock edge, and the last 16 sampled bits form the search window in arrival order. A group value is written with its first-arriving bit as the most significant bit, so the pattern 1,1,0,1 is the value 4'b1101.
- R2: A window is a sync word when groups one, two and four (oldest first) equal 4'b1101 and group three holds any of the other fifteen values.
- R3: `detect_o` is high during exactly the clock cycle that follows the edge sampling the sixteenth bit of a sync word. It is a one-cycle pulse.
- R4: Three or four consecutive 4'b1101 groups never produce a detect in either mode.
- R5: While `rst_n` is low, `detect_o` is low. Bits sampled before reset never contribute to a later detect.
- R6: In free-running mode (LOCK_MODE=0), every sync word is reported, whatever its bit offset, including two words that share a group.
- R7: In lock mode (LOCK_MODE=1), once the newest group equals 4'b1101 while hunting, the block commits to that alignment. While committed, no other alignment can start a group sequence or produce a detect.
- R8: In lock mode, committed groups are judged only every 4 cycles, on boundaries counted from the first group. Groups two and four must match, and group three must not match.
- R9: In lock mode, a group that fails its condition ends the commitment. If that failing group is itself 4'b1101, it is taken at once as a new first group. Otherwise, hunting resumes at every bit.
- R10: In lock mode, the commitment is released after a detect. The final group of the detected word is not reused as the first group of another word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data bit |
| detect_o | output | 1 | One-cycle pulse marking a complete sync word |

## Verification
The assertions take two things for granted.

- The serial input is a known 0 or 1 at every sampling edge once reset is released.
- Reset is held for at least one clock edge, so the window starts from all zeros.

The stimulus meets both conditions:

- It drives only defined bits.
- It changes the input midway between edges.
- It starts each test with a reset of several cycles.

It drives whole groups of known values, so the commitment, boundary and release properties in lock mode are exercised on streams whose expected outcome is computed bit by bit.

// File: rtl/swf_pkg.sv
package swf_pkg;

  // Search state of the locked hunt
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } swf_state_e;

endpackage

// File: rtl/swf_window.sv
// Serial-in window register: newest bit enters at bit 0, oldest bit sits at the MSB.
module swf_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  output logic [WIN_W-1:0] win_o
);

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_d;
  logic             shift_en;

  always_comb begin
    shift_en = 1'b1;
    win_d    = {win_q[WIN_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (shift_en) begin
      win_q <= win_d;
    end
  end

  assign win_o = win_q;

endmodule

// File: rtl/swf_group_match.sv
// Compares every group of the window with the group pattern.
// hit_o[0] belongs to the oldest group, hit_o[NUM_GRP-1] to the newest.
module swf_group_match #(
  parameter int               GRP_W   = 4,
  parameter int               NUM_GRP = 4,
  parameter logic [GRP_W-1:0] PATTERN = 4'b1101,
  localparam int              WIN_W   = GRP_W * NUM_GRP
) (
  input  logic [WIN_W-1:0]   win_i,
  output logic [NUM_GRP-1:0] hit_o
);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int HI = WIN_W - 1 - g * GRP_W;
    assign hit_o[g] = (win_i[HI -: GRP_W] == PATTERN);
  end

endmodule

// File: rtl/swf_lock_tracker.sv
// Locked hunt: commit to one group alignment, judge later groups on group boundaries.
module swf_lock_tracker
  import swf_pkg::*;
#(
  parameter int GRP_W   = 4,
  parameter int NUM_GRP = 4,
  parameter int MIS_IDX = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tail_hit_i,
  output logic detect_o
);

  localparam int PH_W  = (GRP_W   > 1) ? $clog2(GRP_W)   : 1;
  localparam int IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(GRP_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_GRP - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_MIS  = IDX_W'(MIS_IDX);

  swf_state_e       state_q, state_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             trk_en;
  logic             at_bound;
  logic             grp_ok;
  logic             hit_last;

  // Next-state logic
  always_comb begin
    at_bound = (state_q == ST_TRACK) && (phase_q == PH_LAST);
    grp_ok   = (idx_q == IDX_MIS) ? !tail_hit_i : tail_hit_i;
    hit_last = at_bound && grp_ok && (idx_q == IDX_LAST);
    trk_en   = (state_q == ST_TRACK) || tail_hit_i;
    state_d  = state_q;
    phase_d  = phase_q;
    idx_d    = idx_q;
    case (state_q)
      ST_HUNT: begin
        if (tail_hit_i) begin
          state_d = ST_TRACK;
          phase_d = '0;
          idx_d   = IDX_ONE;
        end
      end
      ST_TRACK: begin
        if (!at_bound) begin
          phase_d = phase_q + 1'b1;
        end else if (hit_last) begin
          state_d = ST_HUNT;
        end else if (grp_ok) begin
          phase_d = '0;
          idx_d   = idx_q + 1'b1;
        end else if (tail_hit_i) begin
          phase_d = '0;
          idx_d   = IDX_ONE;
        end else begin
          state_d = ST_HUNT;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      phase_q <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (trk_en) begin
        phase_q <= phase_d;
        idx_q   <= idx_d;
      end
    end
  end

  assign detect_o = hit_last;

  // R8: a committed alignment steps its phase by one on every non-boundary cycle
  assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRACK && phase_q != PH_LAST)
      |=> (state_q == ST_TRACK && phase_q == $past(phase_q) + 1'b1));

  // R7: hunting continues while the newest group does not match
  assert_hunt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && !tail_hit_i) |=> (state_q == ST_HUNT));

  // R7: while committed, the expected group is never the first one
  assert_idx_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRACK) |-> (idx_q != '0));

  // R10: after a detect the tracker is hunting again
  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |=> (state_q == ST_HUNT));

endmodule

// File: rtl/sync_word_finder.sv
module sync_word_finder #(
  parameter int               GRP_W     = 4,
  parameter int               NUM_GRP   = 4,
  parameter logic [GRP_W-1:0] PATTERN   = 4'b1101,
  parameter int               MIS_IDX   = 2,
  parameter bit               LOCK_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdata_i,
  output logic detect_o
);

  localparam int                 WIN_W = GRP_W * NUM_GRP;
  localparam logic [NUM_GRP-1:0] WANT  = ~(NUM_GRP'(1) << MIS_IDX);

  logic [WIN_W-1:0]   win;
  logic [NUM_GRP-1:0] grp_hit;
  logic               word_hit;
  logic               det;

  swf_window #(.WIN_W(WIN_W)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_i (sdata_i),
    .win_o (win)
  );

  swf_group_match #(
    .GRP_W   (GRP_W),
    .NUM_GRP (NUM_GRP),
    .PATTERN (PATTERN)
  ) u_match (
    .win_i (win),
    .hit_o (grp_hit)
  );

  assign word_hit = &(~(grp_hit ^ WANT));

  if (LOCK_MODE) begin : g_lock
    swf_lock_tracker #(
      .GRP_W   (GRP_W),
      .NUM_GRP (NUM_GRP),
      .MIS_IDX (MIS_IDX)
    ) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .tail_hit_i (grp_hit[NUM_GRP-1]),
      .detect_o   (det)
    );

    // R2: a locked detect is only ever raised on a window holding a full word
    assert_lock_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      det |-> word_hit);
  end else begin : g_free
    assign det = word_hit;
  end

  assign detect_o = det;

  // R3: detect never lasts two cycles
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |=> !detect_o);

endmodule

// File: tb/tb_sync_word_finder.sv
module tb_sync_word_finder;

  localparam int CLK_P = 10;
  localparam logic [3:0] PAT = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic det_f, det_l;

  int errors = 0;
  int checks = 0;
  int cnt_f = 0;
  int cnt_l = 0;

  // model state
  logic [15:0] mh = '0;
  bit mlk = 0;
  int mcnt = 0;
  int midx = 0;
  bit exp_f = 0;
  bit exp_l = 0;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  sync_word_finder #(.LOCK_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .sdata_i(din), .detect_o(det_f));

  sync_word_finder #(.LOCK_MODE(1'b1)) dut_lock (
    .clk(clk), .rst_n(rst_n), .sdata_i(din), .detect_o(det_l));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit word_at(input logic [15:0] h);
    return h[15:12] == PAT && h[11:8] == PAT && h[7:4] != PAT && h[3:0] == PAT;
  endfunction

  task automatic m_edge(input logic b);
    bit tail, atb, ok;
    tail = (mh[3:0] == PAT);
    atb  = mlk && mcnt == 3;
    ok   = (midx == 2) ? !tail : tail;
    if (!mlk) begin
      if (tail) begin mlk = 1; mcnt = 0; midx = 1; end
    end else if (!atb) mcnt++;
    else if (ok && midx != 3) begin mcnt = 0; midx++; end
    else if (ok) mlk = 0;
    else if (tail) begin mcnt = 0; midx = 1; end
    else mlk = 0;
    mh = {mh[14:0], b};
    exp_f = word_at(mh);
    exp_l = mlk && mcnt == 3 && midx == 3 && mh[3:0] == PAT;
  endtask

  task automatic step(input logic b, input string tag);
    @(negedge clk);
    check(det_f === exp_f, {tag, " free"}, int'(det_f), int'(exp_f));
    check(det_l === exp_l, {tag, " lock"}, int'(det_l), int'(exp_l));
    if (det_f === 1'b1) cnt_f++;
    if (det_l === 1'b1) cnt_l++;
    din = b;
    m_edge(b);
  endtask

  task automatic send_nib(input logic [3:0] v, input string tag);
    for (int i = 3; i >= 0; i--) step(v[i], tag);
  endtask

  task automatic send_word(input logic [3:0] g3, input string tag);
    send_nib(PAT, tag); send_nib(PAT, tag); send_nib(g3, tag); send_nib(PAT, tag);
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din = 1'b0;
    repeat (3) @(negedge clk);
    check(det_f === 1'b0, "R5 reset free", int'(det_f), 0);
    check(det_l === 1'b0, "R5 reset lock", int'(det_l), 0);
    mh = '0; mlk = 0; mcnt = 0; midx = 0; exp_f = 0; exp_l = 0;
    rst_n = 1'b1;
    cnt_f = 0; cnt_l = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    // R2 R3 R4: every value of the third group
    for (int v = 0; v < 16; v++) begin
      do_reset();
      zeros(5, "R3");
      send_word(4'(v), "R2 R3");
      zeros(20, "R3");
      check(cnt_f == ((v != 13) ? 1 : 0), "R2 R4 free count", cnt_f, (v != 13) ? 1 : 0);
      check(cnt_l == ((v != 13) ? 1 : 0), "R2 R4 lock count", cnt_l, (v != 13) ? 1 : 0);
    end

    // R4: runs of four and five pattern groups
    do_reset();
    for (int i = 0; i < 5; i++) send_nib(PAT, "R4");
    zeros(20, "R4");
    check(cnt_f == 0, "R4 free count", cnt_f, 0);
    check(cnt_l == 0, "R4 lock count", cnt_l, 0);

    // R6: word at every bit offset behind random prefixes
    for (int off = 0; off < 16; off++) begin
      do_reset();
      for (int i = 0; i < off; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[0], "R1 R6");
      end
      send_word(4'b0000, "R6");
      zeros(20, "R6");
      check(cnt_f >= 1, "R6 free found", cnt_f, 1);
    end

    // R7: decoy group commits the lock and hides an overlapping word
    do_reset();
    send_nib(PAT, "R7");
    step(1, "R7"); step(1, "R7"); step(0, "R7");
    send_word(4'b0000, "R7");
    zeros(20, "R7");
    check(cnt_f == 1, "R7 free count", cnt_f, 1);
    check(cnt_l == 0, "R7 lock count", cnt_l, 0);

    // R9: failed third group taken as new first group
    do_reset();
    for (int i = 0; i < 4; i++) send_nib(PAT, "R9");
    send_nib(4'b0110, "R9 R8");
    send_nib(PAT, "R9 R8");
    zeros(20, "R9");
    check(cnt_f == 1, "R9 free count", cnt_f, 1);
    check(cnt_l == 1, "R9 lock count", cnt_l, 1);

    // R10: two words sharing a group
    do_reset();
    send_word(4'b0000, "R10");
    send_nib(PAT, "R10"); send_nib(4'b0000, "R10"); send_nib(PAT, "R10");
    zeros(20, "R10");
    check(cnt_f == 2, "R6 R10 free count", cnt_f, 2);
    check(cnt_l == 1, "R10 lock count", cnt_l, 1);

    // R10: back-to-back words without sharing
    do_reset();
    send_word(4'b1111, "R10");
    send_word(4'b0010, "R10");
    zeros(20, "R10");
    check(cnt_l == 2, "R10 lock back-to-back", cnt_l, 2);

    // R5: reset in the middle of a word
    do_reset();
    send_nib(PAT, "R5"); send_nib(PAT, "R5"); send_nib(4'b0000, "R5");
    step(1, "R5"); step(1, "R5"); step(0, "R5");
    do_reset();
    step(1, "R5");
    zeros(20, "R5");
    check(cnt_f == 0, "R5 free after reset", cnt_f, 0);
    check(cnt_l == 0, "R5 lock after reset", cnt_l, 0);

    // R1 R6 R8: long random stream with injected words
    do_reset();
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) send_word(lf[7:4], "R6 R8");
      else if (lf[2:0] == 3'd1) send_nib(PAT, "R8");
      else for (int i = 0; i < 6; i++) step(lf[i + 5], "R1 R8");
    end
    zeros(20, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule